// File: doc/BRIEF.md
# Serial Control Register Port

This block is the slave end of a one-wire serial link that writes and reads a bank of eight 12-bit control registers. A host sends 16-bit frames on `ser_in`. Each frame opens with a zero start bit and is followed by a stop bit of one. The direction of a frame is taken from `rd_nwr`. All sampling happens on the fast clock `clk`, but only in cycles where the quarter-rate strobe `word_stb` is high. Those qualified edges are called "ticks" below.

A write frame loads its 12 data bits into the register named by the three address bits at the end of the frame. The registers are always visible in parallel on `ctrl_regs`, where they feed the circuits they control. A read frame instead streams the addressed register back out on `ser_out`, most significant bit first. While `suspend` is high, the port ignores frames.

Top module: `ctrl_serial_port`

## Requirements
- R1: Frame layout, in order of arrival. Tick 0 is the start bit and must be 0. Ticks 1 to 12 carry data bits D11 down to D0. Ticks 13 to 15 carry address bits A2 down to A0. Tick 16 is the stop bit.
- R2: `ser_in`, `rd_nwr` and `suspend` are sampled only on rising `clk` edges where `word_stb` is 1. Values on other edges have no effect. The strobe is high one cycle in four.
- R3: While idle, the receiver starts a frame only when it samples a 0 at a tick. A line held at 1 keeps it idle for any number of ticks.
- R4: The stop tick must see a 1. Otherwise the frame is discarded: no register changes, no readback starts, and the receiver returns to idle.
- R5: `rd_nwr` is sampled at the start-bit tick, with 1 meaning read and 0 meaning write. Changes later in the frame have no effect.
- R6: A write frame with a valid stop bit replaces exactly the addressed register, at the edge of the stop tick. All other registers keep their values. Register i appears on `ctrl_regs[12*i+11 : 12*i]`.
- R7: A read frame with a valid stop bit leaves all registers unchanged. After the stop-tick edge, `ser_out` shows D11 of the addressed register. It then advances one bit per tick down to D0. The data field of a read frame is ignored.
- R8: A tick with `suspend` = 1 aborts any frame in progress and keeps the receiver idle. A frame touched by suspend therefore neither writes nor reads.
- R9: After reset, every register is 0, `ser_out` is 1, and the receiver is idle.
- R10: `ser_out` is 1 whenever no readback is being shifted, including from the tick after D0 onward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_stb | input | 1 | Quarter-rate strobe that qualifies sampling |
| suspend | input | 1 | 1 blocks all register access |
| ser_in | input | 1 | Serial frame input |
| rd_nwr | input | 1 | Direction, sampled with the start bit (1 = read) |
| ser_out | output | 1 | Serial readback, idles at 1 |
| ctrl_regs | output | 96 | All eight registers side by side, register 0 in the low bits |

## Verification
Writes go to every address with all-ones, all-zeros, single-end-bit and alternating patterns. Each write is compared against the full parallel register view, so a wrong address decode or a shifted data field shows up as a mismatch in a neighbour. Reads carry a data field that differs from the stored value, which separates the readback from an echo of the frame. During non-strobe cycles the bench drives the inverse of each bit, so sampling on an unqualified edge corrupts the frame or starts a false one. Frames with a zero stop bit, frames under suspend from the start or from mid-frame, and direction flips after the start bit check that nothing outside a complete, permitted frame reaches the registers or the output.

// File: rtl/ctrl_port_pkg.sv
package ctrl_port_pkg;
    typedef enum logic [1:0] {
        RX_IDLE = 2'd0,
        RX_BITS = 2'd1,
        RX_STOP = 2'd2
    } rx_state_e;
endpackage

// File: rtl/frame_rx.sv
module frame_rx
    import ctrl_port_pkg::*;
#(
    parameter int FRAME_BITS = 16,
    parameter int ADDR_BITS  = 3,
    parameter int DATA_BITS  = FRAME_BITS - 1 - ADDR_BITS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 word_stb,
    input  logic                 suspend,
    input  logic                 ser_in,
    input  logic                 rd_nwr,
    output logic                 wr_en,
    output logic                 rd_go,
    output logic [ADDR_BITS-1:0] addr,
    output logic [DATA_BITS-1:0] wdata
);
    localparam int BODY = FRAME_BITS - 1;
    localparam int CW   = $clog2(BODY);

    typedef struct packed {
        rx_state_e       st;
        logic            rd;
        logic [CW-1:0]   cnt;
        logic [BODY-1:0] sh;
    } rx_s;

    rx_s s_d, s_q;

    always_comb begin
        s_d   = s_q;
        wr_en = 1'b0;
        rd_go = 1'b0;
        if (word_stb) begin
            if (suspend) begin
                s_d.st  = RX_IDLE;
                s_d.cnt = '0;
            end else begin
                case (s_q.st)
                    RX_IDLE: begin
                        if (!ser_in) begin
                            s_d.st  = RX_BITS;
                            s_d.rd  = rd_nwr;
                            s_d.cnt = '0;
                        end
                    end
                    RX_BITS: begin
                        s_d.sh = {s_q.sh[BODY-2:0], ser_in};
                        if (s_q.cnt == CW'(BODY - 1)) begin
                            s_d.st = RX_STOP;
                        end else begin
                            s_d.cnt = s_q.cnt + 1'b1;
                        end
                    end
                    RX_STOP: begin
                        s_d.st = RX_IDLE;
                        if (ser_in) begin
                            if (s_q.rd) rd_go = 1'b1;
                            else        wr_en = 1'b1;
                        end
                    end
                    default: s_d.st = RX_IDLE;
                endcase
            end
        end
    end

    assign addr  = s_q.sh[ADDR_BITS-1:0];
    assign wdata = s_q.sh[BODY-1:ADDR_BITS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: RX_IDLE, rd: 1'b0, cnt: '0, sh: '0};
        end else begin
            s_q <= s_d;
        end
    end

    AST_STROBE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        !word_stb |=> $stable(s_q)); // R2
    AST_LINE_HIGH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (word_stb && ser_in && s_q.st == RX_IDLE) |=> s_q.st == RX_IDLE); // R3
    AST_SUSPEND_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (word_stb && suspend) |=> (s_q.st == RX_IDLE && !wr_en && !rd_go)); // R8
    AST_DIR_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st != RX_IDLE && !(word_stb && suspend)) |=> $stable(s_q.rd)); // R5
endmodule

// File: rtl/reg_bank.sv
module reg_bank #(
    parameter int ADDR_BITS = 3,
    parameter int DATA_BITS = 12
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  wr_en,
    input  logic [ADDR_BITS-1:0]                  addr,
    input  logic [DATA_BITS-1:0]                  wdata,
    output logic [DATA_BITS-1:0]                  rdata,
    output logic [(2**ADDR_BITS)*DATA_BITS-1:0]   regs_flat
);
    localparam int NREGS = 2 ** ADDR_BITS;

    logic [DATA_BITS-1:0] regs_d [NREGS];
    logic [DATA_BITS-1:0] regs_q [NREGS];

    always_comb begin
        regs_d = regs_q;
        if (wr_en) regs_d[addr] = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREGS; i++) regs_q[i] <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign rdata = regs_q[addr];

    for (genvar g = 0; g < NREGS; g++) begin : g_flat
        assign regs_flat[g*DATA_BITS +: DATA_BITS] = regs_q[g];
    end

    AST_NO_STRAY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(regs_flat)); // R6
endmodule

// File: rtl/rd_shifter.sv
module rd_shifter #(
    parameter int DATA_BITS = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 word_stb,
    input  logic                 load,
    input  logic [DATA_BITS-1:0] ldata,
    output logic                 ser_out
);
    localparam int CW = $clog2(DATA_BITS);

    typedef struct packed {
        logic [DATA_BITS-1:0] sh;
        logic [CW-1:0]        cnt;
        logic                 out;
    } sh_s;

    sh_s s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (load) begin
            s_d.out = ldata[DATA_BITS-1];
            s_d.sh  = {ldata[DATA_BITS-2:0], 1'b1};
            s_d.cnt = CW'(DATA_BITS - 1);
        end else if (word_stb) begin
            if (s_q.cnt != '0) begin
                s_d.out = s_q.sh[DATA_BITS-1];
                s_d.sh  = {s_q.sh[DATA_BITS-2:0], 1'b1};
                s_d.cnt = s_q.cnt - 1'b1;
            end else begin
                s_d.out = 1'b1;
            end
        end
    end

    assign ser_out = s_q.out;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{sh: '1, cnt: '0, out: 1'b1};
        end else begin
            s_q <= s_d;
        end
    end

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!word_stb && !load) |=> $stable(ser_out)); // R2
    AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (word_stb && !load && s_q.cnt == '0) |=> ser_out); // R10
endmodule

// File: rtl/ctrl_serial_port.sv
module ctrl_serial_port #(
    parameter int FRAME_BITS = 16,
    parameter int ADDR_BITS  = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic word_stb,
    input  logic suspend,
    input  logic ser_in,
    input  logic rd_nwr,
    output logic ser_out,
    output logic [(2**ADDR_BITS)*(FRAME_BITS-1-ADDR_BITS)-1:0] ctrl_regs
);
    localparam int DATA_BITS = FRAME_BITS - 1 - ADDR_BITS;

    logic                 wr_en;
    logic                 rd_go;
    logic [ADDR_BITS-1:0] addr;
    logic [DATA_BITS-1:0] wdata;
    logic [DATA_BITS-1:0] rdata;

    frame_rx #(
        .FRAME_BITS(FRAME_BITS),
        .ADDR_BITS (ADDR_BITS),
        .DATA_BITS (DATA_BITS)
    ) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .word_stb(word_stb),
        .suspend (suspend),
        .ser_in  (ser_in),
        .rd_nwr  (rd_nwr),
        .wr_en   (wr_en),
        .rd_go   (rd_go),
        .addr    (addr),
        .wdata   (wdata)
    );

    reg_bank #(
        .ADDR_BITS(ADDR_BITS),
        .DATA_BITS(DATA_BITS)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .addr     (addr),
        .wdata    (wdata),
        .rdata    (rdata),
        .regs_flat(ctrl_regs)
    );

    rd_shifter #(
        .DATA_BITS(DATA_BITS)
    ) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .word_stb(word_stb),
        .load    (rd_go),
        .ldata   (rdata),
        .ser_out (ser_out)
    );

    AST_READ_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_go |=> $stable(ctrl_regs)); // R7
endmodule

// File: tb/ctrl_serial_port_test.sv
`timescale 1ns/1ps
module ctrl_serial_port_test;
    localparam int AB = 3;
    localparam int DB = 12;
    localparam int NR = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic word_stb = 1'b0;
    logic suspend = 1'b0;
    logic ser_in = 1'b1;
    logic rd_nwr = 1'b0;
    logic ser_out;
    logic [NR*DB-1:0] ctrl_regs;

    logic [DB-1:0] model [NR];
    int n_tests = 0;
    int n_fail  = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    ctrl_serial_port uut (
        .clk(clk), .rst_n(rst_n), .word_stb(word_stb), .suspend(suspend),
        .ser_in(ser_in), .rd_nwr(rd_nwr), .ser_out(ser_out), .ctrl_regs(ctrl_regs)
    );

    task automatic check(input string req, input logic [NR*DB-1:0] act, input logic [NR*DB-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [NR*DB-1:0] model_flat();
        logic [NR*DB-1:0] v;
        for (int i = 0; i < NR; i++) v[i*DB +: DB] = model[i];
        return v;
    endfunction

    // One strobe-qualified cycle; the inverse bit sits on the line on the other three.
    task automatic tick(input logic b);
        @(negedge clk);
        ser_in   = b;
        word_stb = 1'b1;
        @(negedge clk);
        word_stb = 1'b0;
        ser_in   = ~b;
        repeat (2) @(negedge clk);
    endtask

    // susp_from: tick index (0..16) where suspend rises; 17 = never.
    task automatic send_frame(input logic rw, input logic [AB-1:0] a, input logic [DB-1:0] d,
                              input logic stop, input int susp_from);
        logic b;
        for (int k = 0; k <= 16; k++) begin
            suspend = (k >= susp_from);
            rd_nwr  = (k == 0) ? rw : ~rw;
            if (k == 0)       b = 1'b0;
            else if (k <= 12) b = d[12-k];
            else if (k <= 15) b = a[15-k];
            else              b = stop;
            tick(b);
        end
        suspend = 1'b0;
    endtask

    task automatic write_reg(input logic [AB-1:0] a, input logic [DB-1:0] d);
        send_frame(1'b0, a, d, 1'b1, 17);
        model[a] = d;
        check("R6 write hits only addressed register", ctrl_regs, model_flat());
    endtask

    // Collects ser_out after the stop tick and 11 more ticks, then one tick after D0.
    task automatic read_reg(input logic [AB-1:0] a, input logic [DB-1:0] junk, input logic stop,
                            input int susp_from, input string req);
        logic [DB-1:0] got;
        logic [DB-1:0] exp;
        send_frame(1'b1, a, junk, stop, susp_from);
        got[DB-1] = ser_out;
        for (int i = DB - 2; i >= 0; i--) begin
            tick(1'b1);
            got[i] = ser_out;
        end
        exp = (stop && susp_from > 16) ? model[a] : '1;
        check(req, got, exp);
        tick(1'b1);
        check("R10 output back to 1 after D0", ser_out, 1'b1);
        check("R7 read leaves registers unchanged", ctrl_regs, model_flat());
    endtask

    task automatic t_reset();
        check("R9 registers zero after reset", ctrl_regs, '0);
        check("R9 ser_out high after reset", ser_out, 1'b1);
    endtask

    task automatic t_idle_line();
        for (int i = 0; i < 20; i++) tick(1'b1);
        check("R3 line at 1 starts nothing", ctrl_regs, '0);
        check("R10 ser_out idle high", ser_out, 1'b1);
    endtask

    task automatic t_write_all();
        write_reg(3'd5, 12'hA5C);
        write_reg(3'd0, 12'hFFF);
        write_reg(3'd7, 12'h800);
        write_reg(3'd1, 12'h001);
        write_reg(3'd2, 12'h555);
        write_reg(3'd3, 12'hAAA);
        write_reg(3'd4, 12'h3C3);
        write_reg(3'd6, 12'h0F0);
        write_reg(3'd0, 12'h000);
        write_reg(3'd0, 12'h7E1);
    endtask

    task automatic t_read_all();
        for (int a = 0; a < NR; a++)
            read_reg(3'(a), ~model[a], 1'b1, 17, "R7 readback MSB first (R1 layout)");
    endtask

    task automatic t_no_stop();
        send_frame(1'b0, 3'd2, 12'h123, 1'b0, 17);
        tick(1'b1);
        check("R4 write without stop discarded", ctrl_regs, model_flat());
        read_reg(3'd0, 12'h000, 1'b0, 17, "R4 read without stop gives no data");
        write_reg(3'd2, 12'h9B4);
    endtask

    task automatic t_suspend();
        send_frame(1'b0, 3'd4, 12'hDEF, 1'b1, 0);
        tick(1'b1);
        check("R8 write under suspend ignored", ctrl_regs, model_flat());
        send_frame(1'b0, 3'd4, 12'h246, 1'b1, 8);
        tick(1'b1);
        check("R8 write aborted mid-frame", ctrl_regs, model_flat());
        read_reg(3'd5, 12'h000, 1'b1, 3, "R8 read under suspend gives no data");
        write_reg(3'd4, 12'h1E7);
    endtask

    task automatic t_direction();
        // send_frame flips rd_nwr after the start tick; R5 checked by outcome
        write_reg(3'd6, 12'hC0D);
        read_reg(3'd6, 12'h3F2, 1'b1, 17, "R5 direction latched at start bit");
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        for (int i = 0; i < NR; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_idle_line();
        t_write_all();
        t_read_all();
        t_no_stop();
        t_suspend();
        t_direction();
        finish_run();
    end

    initial begin
        #500000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule